// File: doc/BRIEF.md
# Raised-Cosine Soft Mute Controller

This block sits in a stereo PCM path and multiplies every left/right sample pair by a common gain. When a mute is requested the gain travels from unity to zero along a raised-cosine curve, one table step per valid sample, and it climbs back the same way when the mute is released. The curve has 33 points in 1.15 fixed point, so a full transition takes 32 sample periods.

A mute request comes from one of two sources: a dedicated mute pin or a mute bit held in a control register. A mode input decides which one is honoured, and the other is ignored. Apart from that request, losing clock-recovery lock can silence the output at once, with no ramp. This only happens while the automatic-mute enable is set. After reset the gain sits at zero, as if the register mute bit still held its default of 1. The block raises a muted flag while the gain is exactly zero.

The block is used inline, between the sample source and the converter. Each input sample is qualified by a valid strobe, and the scaled sample comes out one clock later with its own strobe.

Top module: `soft_mute_ctrl`

## Requirements
- R1: After reset the gain position is at zero gain: `muted` is 1, `outValid` is 0, and the first valid sample after reset leaves the block as 0.
- R2: Gain position k runs from 0 (unity) to 32 (silence), and the applied gain is round(32768 * 0.5 * (1 + cos(pi*k/32))), with 32768 meaning 1.0. On each valid sample that is not hard-muted, k moves one step toward 32 if a mute is requested and one step toward 0 otherwise. The sample is scaled with the gain of k as it was before the step.
- R3: Each output sample equals (sample * gain) / 32768, truncated toward zero and saturated to the signed 16-bit range. Left and right use the same gain.
- R4: When `pinCtrlMode` is 1 the mute request is `mutePin`. When it is 0 the request is `regMute`. The source that is not selected has no effect on the output.
- R5: When `autoMuteEn` is 1 and `lockOk` is 0, a sample accepted in that cycle leaves the block as 0. The position jumps straight to 32, whether or not a sample is valid.
- R6: When `autoMuteEn` is 0, `lockOk` has no effect on the output.
- R7: Releasing a mute partway through a ramp reverses the ramp from its current position, with no restart from either end. The same holds for requesting a mute partway through an unmute ramp.
- R8: `muted` is 1 exactly when the current position is 32 (gain zero). A valid sample accepted while `muted` is 1 leaves the block as 0.
- R9: `outValid` pulses one clock after each `inValid`. Output samples hold their value between valid samples. The position does not move on cycles without a valid sample unless R5 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample pair valid strobe |
| inLeft | input | 16 | Left input sample, signed |
| inRight | input | 16 | Right input sample, signed |
| lockOk | input | 1 | Clock-recovery lock indication |
| autoMuteEn | input | 1 | Enables hard mute on loss of lock |
| pinCtrlMode | input | 1 | 1 selects the mute pin, 0 selects the register mute bit |
| mutePin | input | 1 | Mute request from the static pin |
| regMute | input | 1 | Mute request from the control register bit |
| outValid | output | 1 | Output sample pair valid strobe |
| outLeft | output | 16 | Scaled left sample, signed |
| outRight | output | 16 | Scaled right sample, signed |
| muted | output | 1 | High while the gain is exactly zero |

## Verification
The bench drives the full ramp in both directions with full-scale positive and negative samples. A wrong table entry or a rounding that goes away from zero instead of toward it then shows up as a one-LSB error at some point on the curve. It flips the mute request in the middle of a ramp, so a design that restarts the ramp is caught by the jump in gain. It also toggles the source that is not selected, so a design that listens to the wrong source is caught. Loss of lock is applied with the automatic mute both enabled and disabled, which catches a design that ramps instead of cutting, or one that ignores the enable. Gaps between valid strobes catch a position that advances on idle cycles, and catch outputs that do not hold their value.

// File: rtl/smute_pkg.sv
package smute_pkg;
  localparam int RAMP_LOG2 = 5;               // gain table is built for 32 steps
  localparam int RAMP_STEPS = 1 << RAMP_LOG2;
  localparam int IDX_W = RAMP_LOG2 + 1;
  localparam int SAMPLE_W = 16;
  localparam int GAIN_W = 16;                 // unsigned, 32768 == 1.0
  localparam int GAIN_FRAC = 15;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;                 // capture and scale this sample pair
    logic forceZero;            // hard mute: apply zero gain
    logic [IDX_W-1:0] idx;      // gain position before this step
  } smute_cmd_t;
endpackage

// File: rtl/smute_gain_rom.sv
module smute_gain_rom
  import smute_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int GW = GAIN_W
) (
  input  logic [IW-1:0] idx,
  output logic [GW-1:0] gain
);
  // 0.5*(1+cos(pi*k/32)) scaled by 32768, rounded to nearest
  always_comb begin
    case (idx)
      IW'(0):  gain = GW'(32768);
      IW'(1):  gain = GW'(32689);
      IW'(2):  gain = GW'(32453);
      IW'(3):  gain = GW'(32063);
      IW'(4):  gain = GW'(31521);
      IW'(5):  gain = GW'(30833);
      IW'(6):  gain = GW'(30007);
      IW'(7):  gain = GW'(29049);
      IW'(8):  gain = GW'(27969);
      IW'(9):  gain = GW'(26778);
      IW'(10): gain = GW'(25486);
      IW'(11): gain = GW'(24107);
      IW'(12): gain = GW'(22654);
      IW'(13): gain = GW'(21140);
      IW'(14): gain = GW'(19580);
      IW'(15): gain = GW'(17990);
      IW'(16): gain = GW'(16384);
      IW'(17): gain = GW'(14778);
      IW'(18): gain = GW'(13188);
      IW'(19): gain = GW'(11628);
      IW'(20): gain = GW'(10114);
      IW'(21): gain = GW'(8661);
      IW'(22): gain = GW'(7282);
      IW'(23): gain = GW'(5990);
      IW'(24): gain = GW'(4799);
      IW'(25): gain = GW'(3719);
      IW'(26): gain = GW'(2761);
      IW'(27): gain = GW'(1935);
      IW'(28): gain = GW'(1247);
      IW'(29): gain = GW'(705);
      IW'(30): gain = GW'(315);
      IW'(31): gain = GW'(79);
      default: gain = '0;
    endcase
  end
endmodule

// File: rtl/smute_scale.sv
module smute_scale #(
  parameter int SW = 16,
  parameter int GW = 16,
  parameter int FRAC = 15
) (
  input  logic signed [SW-1:0] sampleIn,
  input  logic [GW-1:0]        gain,
  output logic signed [SW-1:0] sampleOut
);
  localparam int PW = SW + GW + 1;
  localparam logic signed [PW-1:0] MAX_V = PW'((2 ** (SW - 1)) - 1);
  localparam logic signed [PW-1:0] MIN_V = -PW'(2 ** (SW - 1));
  localparam logic signed [PW-1:0] BIAS = PW'((2 ** FRAC) - 1);

  logic signed [PW-1:0] sExt, gExt, prod, biased, shifted;

  always_comb begin
    sExt = PW'(sampleIn);
    gExt = PW'({1'b0, gain});
    prod = sExt * gExt;
    // add bias on negatives so the arithmetic shift truncates toward zero
    biased = (prod < 0) ? prod + BIAS : prod;
    shifted = biased >>> FRAC;
    if (shifted > MAX_V) sampleOut = MAX_V[SW-1:0];
    else if (shifted < MIN_V) sampleOut = MIN_V[SW-1:0];
    else sampleOut = shifted[SW-1:0];
  end

  // gain never exceeds 1.0, so magnitude must not grow
  always_comb begin
    if (gain <= GW'(2 ** FRAC))
      AST_NO_OVERFLOW: assert ((sampleOut >= 0 ? PW'(sampleOut) : -PW'(sampleOut))
                               <= (sampleIn >= 0 ? sExt : -sExt)); // R3
  end
endmodule

// File: rtl/smute_ctrl.sv
module smute_ctrl
  import smute_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int STEPS = RAMP_STEPS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       lockOk,
  input  logic       autoMuteEn,
  input  logic       pinCtrlMode,
  input  logic       mutePin,
  input  logic       regMute,
  output smute_cmd_t cmd,
  output logic       muted
);
  localparam logic [IW-1:0] POS_ZERO = IW'(STEPS);
  localparam logic [IW-1:0] POS_UNITY = '0;

  logic [IW-1:0] pos;
  logic muteReq, hardMute;

  assign muteReq = pinCtrlMode ? mutePin : regMute;
  assign hardMute = autoMuteEn & ~lockOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos <= POS_ZERO;                      // register mute bit defaults to 1
    end else if (hardMute) begin
      pos <= POS_ZERO;
    end else if (inValid) begin
      if (muteReq && pos != POS_ZERO) pos <= pos + IW'(1);
      else if (!muteReq && pos != POS_UNITY) pos <= pos - IW'(1);
    end
  end

  always_comb begin
    cmd.load = inValid;
    cmd.forceZero = hardMute;
    cmd.idx = pos;
  end

  assign muted = (pos == POS_ZERO);

  AST_HARD_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    hardMute |=> pos == POS_ZERO); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!hardMute && !inValid) |=> $stable(pos)); // R9
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!hardMute && inValid && muteReq && pos != POS_ZERO) |=> pos == $past(pos) + IW'(1)); // R2
  AST_REVERSE: assert property (@(posedge clk) disable iff (!rstN)
    (!hardMute && inValid && !muteReq && pos != POS_UNITY) |=> pos + IW'(1) == $past(pos)); // R7
endmodule

// File: rtl/smute_datapath.sv
module smute_datapath
  import smute_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int GW = GAIN_W,
  parameter int FRAC = GAIN_FRAC
) (
  input  logic          clk,
  input  logic          rstN,
  input  smute_cmd_t    cmd,
  input  logic [SW-1:0] inLeft,
  input  logic [SW-1:0] inRight,
  output logic          outValid,
  output logic [SW-1:0] outLeft,
  output logic [SW-1:0] outRight
);
  localparam int NCH = 2;

  logic [GW-1:0] romGain, gain;
  logic [SW-1:0] chIn [NCH];
  logic [SW-1:0] chOut [NCH];
  logic [SW-1:0] chReg [NCH];

  smute_gain_rom #(.IW(IDX_W), .GW(GW)) uRom (.idx(cmd.idx), .gain(romGain));

  assign gain = cmd.forceZero ? '0 : romGain;
  assign chIn[0] = inLeft;
  assign chIn[1] = inRight;

  for (genvar c = 0; c < NCH; c++) begin : gCh
    smute_scale #(.SW(SW), .GW(GW), .FRAC(FRAC)) uScale (
      .sampleIn(chIn[c]), .gain(gain), .sampleOut(chOut[c]));

    always_ff @(posedge clk) begin
      if (!rstN) chReg[c] <= '0;
      else if (cmd.load) chReg[c] <= chOut[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else outValid <= cmd.load;
  end

  assign outLeft = chReg[0];
  assign outRight = chReg[1];

  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && cmd.forceZero) |=> (outLeft == '0 && outRight == '0)); // R5
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> outValid); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> (!outValid && $stable(outLeft) && $stable(outRight))); // R9
endmodule

// File: rtl/soft_mute_ctrl.sv
module soft_mute_ctrl
  import smute_pkg::*;
#(
  parameter int SW = SAMPLE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [SW-1:0] inLeft,
  input  logic [SW-1:0] inRight,
  input  logic          lockOk,
  input  logic          autoMuteEn,
  input  logic          pinCtrlMode,
  input  logic          mutePin,
  input  logic          regMute,
  output logic          outValid,
  output logic [SW-1:0] outLeft,
  output logic [SW-1:0] outRight,
  output logic          muted
);
  smute_cmd_t cmd;

  smute_ctrl #(.IW(IDX_W), .STEPS(RAMP_STEPS)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .lockOk(lockOk),
    .autoMuteEn(autoMuteEn), .pinCtrlMode(pinCtrlMode), .mutePin(mutePin),
    .regMute(regMute), .cmd(cmd), .muted(muted));

  smute_datapath #(.SW(SW), .GW(GAIN_W), .FRAC(GAIN_FRAC)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inLeft(inLeft), .inRight(inRight),
    .outValid(outValid), .outLeft(outLeft), .outRight(outRight));

  AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (muted && inValid) |=> (outLeft == '0 && outRight == '0)); // R8
endmodule

// File: tb/tb_soft_mute_ctrl.sv
module tb_soft_mute_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] inLeft = '0, inRight = '0;
  logic lockOk = 1'b1, autoMuteEn = 1'b1, pinCtrlMode = 1'b0, mutePin = 1'b0, regMute = 1'b1;
  logic outValid, muted;
  logic [15:0] outLeft, outRight;

  int nChecks = 0, nFails = 0;
  string curReq = "R1";
  int mPos = 32;
  logic expValid = 1'b0;
  int expL = 0, expR = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  soft_mute_ctrl dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .lockOk(lockOk), .autoMuteEn(autoMuteEn), .pinCtrlMode(pinCtrlMode),
    .mutePin(mutePin), .regMute(regMute), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight), .muted(muted));

  function automatic int gainRef(int k);
    real g;
    g = 32768.0 * 0.5 * (1.0 + $cos(3.14159265358979 * k / 32.0));
    return $rtoi(g + 0.5);
  endfunction

  function automatic int scaleRef(int s, int g);
    longint p;
    longint q;
    p = longint'(s) * longint'(g);
    q = p / 32768;                       // truncates toward zero
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at a negedge, predict, wait one cycle, compare
  task automatic cycle(bit v, int l, int r);
    bit hard, req;
    inValid = v;
    inLeft = 16'(l);
    inRight = 16'(r);
    hard = autoMuteEn && !lockOk;
    req = pinCtrlMode ? mutePin : regMute;
    expValid = v;
    if (v) begin
      expL = scaleRef(l, hard ? 0 : gainRef(mPos));
      expR = scaleRef(r, hard ? 0 : gainRef(mPos));
    end
    if (hard) mPos = 32;
    else if (v) begin
      if (req && mPos != 32) mPos++;
      else if (!req && mPos != 0) mPos--;
    end
    @(negedge clk);
    check("R9", "outValid", int'(outValid), int'(expValid));
    check(curReq, "outLeft", int'($signed(outLeft)), expL);
    check(curReq, "outRight", int'($signed(outRight)), expR);
    check("R8", "muted", int'(muted), int'(mPos == 32));
  endtask

  task automatic run(int n, bit v, int l, int r);
    for (int i = 0; i < n; i++) cycle(v, l, r);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", "muted after reset", int'(muted), 1);
    check("R1", "outValid after reset", int'(outValid), 0);

    // R1: first sample after reset is silent; pin ignored in register mode (R4)
    autoMuteEn = 1; lockOk = 1; pinCtrlMode = 0; regMute = 0; mutePin = 1;
    curReq = "R1";
    cycle(1, 32767, -32768);

    // R2: walk the whole curve up to unity with full-scale inputs
    curReq = "R2";
    for (int i = 0; i < 34; i++) cycle(1, (i % 2) ? -32768 : 32767, (i % 2) ? 32767 : -32768);

    // R3: rounding toward zero and extremes along a mute ramp
    curReq = "R3";
    regMute = 1;
    for (int i = 0; i < 34; i++) cycle(1, (i % 3 == 0) ? -1 : -12345, (i % 3 == 1) ? 1 : 23457);

    // R9: gaps between valid samples leave position and outputs alone
    curReq = "R9";
    regMute = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(1, 20000, -20000);
      run(3, 0, 777, -777);
    end

    // R7: reverse mid-ramp in both directions
    curReq = "R7";
    run(40, 1, 30000, -30001);
    regMute = 1;
    run(10, 1, 30000, -30001);
    regMute = 0;
    run(6, 1, 30000, -30001);
    regMute = 1;
    run(3, 1, 30000, -30001);
    regMute = 0;
    run(20, 1, 30000, -30001);

    // R4: pin mode ignores the register bit
    curReq = "R4";
    pinCtrlMode = 1; mutePin = 0;
    for (int i = 0; i < 20; i++) begin
      regMute = i[0];
      cycle(1, 16000, -16000);
    end
    mutePin = 1;
    run(40, 1, 16000, -16000);
    regMute = 0;
    run(5, 1, 16000, -16000);
    pinCtrlMode = 0;

    // R5: loss of lock cuts instantly, with and without a valid sample
    curReq = "R5";
    run(40, 1, 25000, 25000);
    lockOk = 0;
    cycle(1, 25000, 25000);
    lockOk = 1;
    run(5, 1, 25000, 25000);
    run(40, 1, 25000, 25000);
    lockOk = 0;
    cycle(0, 1, 1);
    lockOk = 1;
    run(3, 1, 25000, 25000);

    // R6: disabled auto mute ignores lock
    curReq = "R6";
    run(40, 1, -25000, 12000);
    autoMuteEn = 0; lockOk = 0;
    run(12, 1, -25000, 12000);
    lockOk = 1; autoMuteEn = 1;

    // random mix
    curReq = "R3";
    for (int i = 0; i < 4000; i++) begin
      int l, r;
      if ($urandom_range(39) == 0) regMute = ~regMute;
      if ($urandom_range(39) == 0) mutePin = ~mutePin;
      if ($urandom_range(199) == 0) pinCtrlMode = ~pinCtrlMode;
      if ($urandom_range(149) == 0) autoMuteEn = ~autoMuteEn;
      lockOk = ($urandom_range(99) != 0);
      l = int'($signed(16'($urandom)));
      r = int'($signed(16'($urandom)));
      if ($urandom_range(9) == 0) l = -32768;
      if ($urandom_range(9) == 0) r = 32767;
      cycle(bit'($urandom_range(1)), l, r);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule